// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Controller

This block watches the hot-plug detect line of a display transmitter and turns its changes into interrupt events. The raw line is first brought into the clock domain through a short synchronizer. A deglitch filter then checks it on a slow sample tick, and the tick period is set by a programmable power-of-two prescaler. The filtered level changes only after the raw line has held a new value for a programmed number of consecutive ticks.

Changes of the filtered level set sticky status bits: one bit for connect (rising) and one for disconnect (falling). A level interrupt from a separate transmitter core is merged into the same status word. Software reads the status, writes the same value back to clear the latched edges, and enables sources onto one interrupt output through an active-high mask.

The register port is a plain single-cycle write strobe with a word address. Read data is combinational from the address.

Top module: `hpdi_top`

## Requirements
- R1: After reset, the filter register reads 0xA0A0, the mask reads 0, the status reads 0, the level register reads 0, and `irq` is low.
- R2: The filter register is at address 0. Bits 15:12 hold a prescaler exponent E, so the sample tick occurs once every 2^E clocks. Bits 7:0 hold a count N. The filtered level takes the synchronized raw value on the N-th consecutive tick at which the two differ; N=0 acts as 1. Bits 11:8 read back as zero.
- R3: A raw pulse that lasts fewer sample ticks than N changes neither the filtered level nor any status bit.
- R4: The level register is at address 1. Bit 0 reads 1 when the filtered level shows a sink is present, and 0 otherwise.
- R5: A rising edge of the filtered level sets status bit 1, which stays set until it is cleared.
- R6: A falling edge of the filtered level sets status bit 2, which stays set until it is cleared.
- R7: Status bit 0 equals the core interrupt input as registered one clock earlier. Writing a 1 to this bit has no lasting effect.
- R8: The status register is at address 2. Writing 1 to bit 1 or bit 2 at that address clears the bit. Writing 0 leaves the bit unchanged.
- R9: If an edge event and a clear of the same bit occur in the same clock, the bit ends up set.
- R10: The mask register is at address 3, bits 2:0, and is active high. `irq` is the OR over all bits of (status AND mask).
- R11: `irq` is a level signal. It stays high while an enabled sticky bit stays set, and it falls once that bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| hpd_raw | input | 1 | Raw hot-plug detect line, asynchronous |
| core_irq | input | 1 | Level interrupt from the transmitter core |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the hot-plug line may change at any time, but that register writes are single-cycle strobes whose address and data are stable in the cycle the strobe is high. The edge-versus-clear collision property also assumes that software clears a bit only by writing to the status address. The bench drives every input shortly after a falling clock edge. It times the one collision case by counting the synchronizer and filter registers, using a filter setting of one tick per clock and N=1. The other filter cases use windows that are comfortably shorter or longer than the programmed tick count.

// File: rtl/hpdi_pkg.sv
package hpdi_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 16;
    localparam int EXP_W    = 4;
    localparam int CNT_W    = 8;
    localparam int NSRC     = 3;

    localparam logic [ADDR_W-1:0] A_FILT  = 2'd0;
    localparam logic [ADDR_W-1:0] A_LEVEL = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_MASK  = 2'd3;

    localparam int SRC_CORE = 0;
    localparam int SRC_RISE = 1;
    localparam int SRC_FALL = 2;

    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [CNT_W-1:0] need;
    } filt_cfg_t;

    localparam filt_cfg_t FILT_RESET = '{exp: 4'hA, need: 8'hA0};

    function automatic logic [DATA_W-1:0] pack_filt(filt_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[15:12] = c.exp;
        w[7:0]   = c.need;
        return w;
    endfunction

    function automatic filt_cfg_t unpack_filt(logic [DATA_W-1:0] w);
        filt_cfg_t c;
        c.exp  = w[15:12];
        c.need = w[7:0];
        return c;
    endfunction
endpackage

// File: rtl/hpdi_tick.sv
module hpdi_tick #(
    parameter int PRE_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [hpdi_pkg::EXP_W-1:0] exp,
    output logic                     tick
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] msk;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    always_comb begin
        msk  = (PRE_W'(1) << exp) - PRE_W'(1);
        tick = ((cnt & msk) == msk);
    end
endmodule

// File: rtl/hpdi_deglitch.sv
module hpdi_deglitch #(
    parameter int SYNC = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     raw,
    input  logic                     tick,
    input  logic [hpdi_pkg::CNT_W-1:0] need,
    output logic                     level
);
    localparam int CW = hpdi_pkg::CNT_W;

    logic [SYNC-1:0] sy;
    logic            sample;
    logic [CW-1:0]   run;
    logic [CW:0]     nxt;

    generate
        if (SYNC == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sy <= '0;
                else     sy <= raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sy <= '0;
                else     sy <= {sy[SYNC-2:0], raw};
            end
        end
    endgenerate

    always_comb begin
        sample = sy[SYNC-1];
        nxt    = {1'b0, run} + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            run   <= '0;
        end else if (tick) begin
            if (sample == level) begin
                run <= '0;
            end else if (nxt >= {1'b0, need}) begin
                level <= sample;
                run   <= '0;
            end else begin
                run <= nxt[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/hpdi_status.sv
module hpdi_status (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      level,
    input  logic                      core_in,
    input  logic                      clr_we,
    input  logic [hpdi_pkg::NSRC-1:0] clr_bits,
    output logic [hpdi_pkg::NSRC-1:0] status
);
    import hpdi_pkg::*;

    logic            level_q;
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;

    always_comb begin
        set_v           = '0;
        set_v[SRC_RISE] = level & ~level_q;
        set_v[SRC_FALL] = ~level & level_q;
        clr_v           = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            status  <= '0;
        end else begin
            level_q          <= level;
            status[SRC_CORE] <= core_in;
            status[SRC_RISE] <= set_v[SRC_RISE] | (status[SRC_RISE] & ~clr_v[SRC_RISE]);
            status[SRC_FALL] <= set_v[SRC_FALL] | (status[SRC_FALL] & ~clr_v[SRC_FALL]);
        end
    end
endmodule

// File: rtl/hpdi_top.sv
module hpdi_top #(
    parameter int PRE_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        hpd_raw,
    input  logic        core_irq,
    output logic        irq
);
    import hpdi_pkg::*;

    filt_cfg_t       cfg;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] status;
    logic            tick;
    logic            level;
    logic            clr_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= FILT_RESET;
            mask_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_FILT) cfg    <= unpack_filt(reg_wdata);
            if (reg_addr == A_MASK) mask_q <= reg_wdata[NSRC-1:0];
        end
    end

    assign clr_we = reg_we && (reg_addr == A_STAT);

    hpdi_tick #(.PRE_W(PRE_W)) u_tick (
        .clk (clk),
        .rst (rst),
        .exp (cfg.exp),
        .tick(tick)
    );

    hpdi_deglitch #(.SYNC(SYNC_STAGES)) u_dg (
        .clk  (clk),
        .rst  (rst),
        .raw  (hpd_raw),
        .tick (tick),
        .need (cfg.need),
        .level(level)
    );

    hpdi_status u_st (
        .clk     (clk),
        .rst     (rst),
        .level   (level),
        .core_in (core_irq),
        .clr_we  (clr_we),
        .clr_bits(reg_wdata[NSRC-1:0]),
        .status  (status)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_FILT:  reg_rdata = pack_filt(cfg);
            A_LEVEL: reg_rdata[0] = level;
            A_STAT:  reg_rdata[NSRC-1:0] = status;
            default: reg_rdata[NSRC-1:0] = mask_q;
        endcase
        irq = |(status & mask_q);
    end
endmodule

// File: rtl/hpdi_chk.sv
module hpdi_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        level,
    input logic [2:0]  status,
    input logic [2:0]  mask,
    input logic        irq,
    input logic        core_irq,
    input logic        we,
    input logic [1:0]  addr,
    input logic [15:0] wdata
);
    AST_LEVEL_HOLDS_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(level));  // R2
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |=> status[1]);  // R5
    AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
        $fell(level) |=> status[2]);  // R6
    AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !(we && addr == 2'd2 && wdata[1])) |=> status[1]);  // R5
    AST_CORE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (status[0] == $past(core_irq)));  // R7
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd2 && wdata[2] && !$fell(level)) |=> !status[2]);  // R8
    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == 3'd0) |-> !irq);  // R10
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (irq && !we && !mask[0]) |=> irq);  // R11
endmodule

bind hpdi_top hpdi_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .level   (level),
    .status  (status),
    .mask    (mask_q),
    .irq     (irq),
    .core_irq(core_irq),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata)
);

// File: tb/sim_hpdi_top.sv
module sim_hpdi_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        hpd_raw = 1'b0;
    logic        core_irq = 1'b0;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] v;

    always #(CLK_NS/2) clk = ~clk;

    hpdi_top u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hpd_raw(hpd_raw),
        .core_irq(core_irq), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 16'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        rd(2'd0, v); chk("R1 filter", v, 16'hA0A0);
        rd(2'd3, v); chk("R1 mask", v, 16'h0);
        rd(2'd2, v); chk("R1 status", v, 16'h0);
        rd(2'd1, v); chk("R1 level", v, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_filter_fields();
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); chk("R2 readback", v, 16'hF0FF);
    endtask

    task automatic t_rise_collision();
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'h0007);
        hpd_raw = 1'b1;
        repeat (3) @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0002;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 16'd0;
        rd(2'd2, v); chk("R9 set wins", v, 16'h0002);
        rd(2'd1, v); chk("R4 level high", v, 16'h0001);
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk("R5 sticky", v, 16'h0002);
        wr(2'd2, 16'h0004);
        rd(2'd2, v); chk("R8 zero keeps", v, 16'h0002);
        wr(2'd2, 16'h0002);
        rd(2'd2, v); chk("R8 one clears", v, 16'h0000);
    endtask

    task automatic t_glitch();
        wr(2'd0, 16'h0004);
        @(negedge clk); hpd_raw = 1'b0;
        repeat (2) @(negedge clk);
        hpd_raw = 1'b1;
        repeat (10) @(negedge clk);
        rd(2'd1, v); chk("R3 level kept", v, 16'h0001);
        rd(2'd2, v); chk("R3 no event", v, 16'h0000);
    endtask

    task automatic t_slow_fall();
        wr(2'd0, 16'h2003);
        @(negedge clk); hpd_raw = 1'b0;
        repeat (7) @(negedge clk);
        rd(2'd1, v); chk("R2 not yet", v, 16'h0001);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R2 settled low", v, 16'h0000);
        rd(2'd2, v); chk("R6 fall latched", v, 16'h0004);
    endtask

    task automatic t_core();
        @(negedge clk); core_irq = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd2, v); chk("R7 core high", v & 16'h1, 16'h1);
        wr(2'd2, 16'h0001);
        rd(2'd2, v); chk("R7 clear ignored", v & 16'h1, 16'h1);
        @(negedge clk); core_irq = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd2, v); chk("R7 core low", v & 16'h1, 16'h0);
    endtask

    task automatic t_irq();
        wr(2'd3, 16'h0000);
        #1 chk("R10 masked off", {15'd0, irq}, 16'h0);
        wr(2'd3, 16'h0002);
        #1 chk("R10 other source", {15'd0, irq}, 16'h0);
        wr(2'd3, 16'h0004);
        #1 chk("R10 enabled", {15'd0, irq}, 16'h1);
        rd(2'd3, v); chk("R10 mask readback", v, 16'h0004);
        repeat (5) @(negedge clk);
        #1 chk("R11 held", {15'd0, irq}, 16'h1);
        wr(2'd2, 16'h0004);
        #1 chk("R11 cleared", {15'd0, irq}, 16'h0);
        wr(2'd3, 16'h0001);
        core_irq = 1'b1;
        @(negedge clk);
        #1 chk("R10 core path", {15'd0, irq}, 16'h1);
        core_irq = 1'b0;
        @(negedge clk);
        #1 chk("R10 core drop", {15'd0, irq}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_filter_fields();
        t_rise_collision();
        t_glitch();
        t_slow_fall();
        t_core();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule